// File: doc/BRIEF.md
# Trace Packet Width Serializer

This block accepts one complete trace record per handshake and streams it out over a narrow trace port, one slice per clock, most significant bit first. A record consists of a 24-bit header followed by a data field. The header carries a 2-bit memory target code, a 2-bit status code, a 2-bit access size code, a 1-bit region flag and a 17-bit address. The data field is 8, 16, 32 or 64 bits long, chosen by the size code.

A 2-bit configuration input selects how many output pins carry data in each beat: 2, 4, 8 or 16. The record length changes with the access size, so the number of beats depends on both the size and the lane width. When the record length is not a whole multiple of the lane width, the last beat is filled out with zeros. A strobe marks every beat that carries data. The input handshake stays closed while a record is being shifted out, and it reopens in the cycle after the final beat.

Top module: `trc_width_serializer`

## Requirements
- R1: After reset, `pkt_ready` is 1, `tp_strobe` is 0 and `tp_data` is all zeros.
- R2: A record is taken at a rising edge where `pkt_valid` and `pkt_ready` are both 1. Its first beat appears in the following cycle. `tp_strobe` is 1 in every beat and has no gaps until the last beat.
- R3: The serial order is fixed. It starts with target[1:0], then status[1:0], then size[1:0], then region, then address[16:0], then the data field, all most significant bit first. The data field is the low 8<<size bits of `pkt_data`, where size code 0/1/2/3 means 8/16/32/64 bits. The target, status and region codes are passed through unchanged (target 0..3 = lower bank, upper bank, peripheral group A, peripheral group B; region 0 = region 1, region 1 = region 2).
- R4: `cfg_width` code 0/1/2/3 gives a lane width W of 2/4/8/16. Each beat is driven on `tp_data[W-1:0]`, with the earlier bit in the higher position, and `tp_data` bits at W and above are 0.
- R5: A record takes ceil((24 + data bits)/W) beats. At W=2 this is 16/20/28/44 beats for sizes 8/16/32/64. At W=16 it is 2/3/4/6 beats.
- R6: The low-order bit positions of the last beat that lie past the end of the record are 0.
- R7: `pkt_ready` is 0 from the accepting edge through the last beat and is 1 in the cycle after the last beat. A record offered while `pkt_ready` is 0 is not lost. It is taken once `pkt_ready` returns.
- R8: `cfg_width` is sampled at the accepting edge. A change while a record is being shifted out does not affect that record and applies to the next one.
- R9: While `tp_strobe` is 0, `tp_data` is all zeros.
- R10: Bits of `pkt_data` above the active data field have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | Lane width code: 0=2, 1=4, 2=8, 3=16 bits |
| pkt_valid | input | 1 | Record offered |
| pkt_ready | output | 1 | Record can be taken this cycle |
| pkt_target | input | 2 | Traced memory target code |
| pkt_stat | input | 2 | Status code |
| pkt_size | input | 2 | Access size code: 0=8, 1=16, 2=32, 3=64 bits |
| pkt_region | input | 1 | Trace region flag |
| pkt_addr | input | 17 | Access address |
| pkt_data | input | 64 | Access data, right-aligned |
| tp_data | output | 16 | Trace port slice |
| tp_strobe | output | 1 | Slice carries valid data |

## Verification
Two events can fall in the same cycle: the final beat of one record and the arrival of a new offer together with a new lane width. The bench holds `pkt_valid` high with a second record and changes `cfg_width` right after the first record is taken. It then judges every beat of the first record against the old width and checks that `pkt_ready` stays low throughout. It finally expects the second record to start exactly two cycles after the first record's last beat, serialized at the new width. A hand-computed record checks the bit order and the zero padding independently of the bench's general model.

// File: rtl/trc_ser_pkg.sv
package trc_ser_pkg;

  // Fixed header fields besides the address: target(2) stat(2) size(2) region(1)
  localparam int unsigned HDR_FIXED_W = 7;
  // Widest data field (size code 3)
  localparam int unsigned DATA_MAX_W  = 64;

  function automatic int unsigned data_bits(input logic [1:0] size_code);
    return 32'd8 << size_code;
  endfunction

  function automatic int unsigned lane_bits(input logic [1:0] width_code);
    return 32'd2 << width_code;
  endfunction

  function automatic int unsigned frame_bits(input logic [1:0] size_code,
                                             input int unsigned hdr_w);
    return hdr_w + data_bits(size_code);
  endfunction

  function automatic int unsigned beats_for(input logic [1:0] size_code,
                                            input logic [1:0] width_code,
                                            input int unsigned hdr_w);
    int unsigned lw;
    lw = lane_bits(width_code);
    return (frame_bits(size_code, hdr_w) + lw - 32'd1) / lw;
  endfunction

  function automatic int unsigned pad_for(input logic [1:0] size_code,
                                          input logic [1:0] width_code,
                                          input int unsigned hdr_w);
    return beats_for(size_code, width_code, hdr_w) * lane_bits(width_code)
           - frame_bits(size_code, hdr_w);
  endfunction

endpackage

// File: rtl/trc_frame_build.sv
module trc_frame_build
  import trc_ser_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned HDR_W   = HDR_FIXED_W + ADDR_W,
  parameter int unsigned FRAME_W = HDR_W + DATA_MAX_W
) (
  input  logic [1:0]            target,
  input  logic [1:0]            stat,
  input  logic [1:0]            size,
  input  logic                  region,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_MAX_W-1:0] data,
  output logic [FRAME_W-1:0]    frame
);

  logic [HDR_W-1:0]      hdr;
  logic [DATA_MAX_W-1:0] keep_mask;
  logic [DATA_MAX_W-1:0] field;
  int unsigned           gap;

  // Header first, then the active data bits moved to the top of the field,
  // leaving zeros behind them as the natural tail padding.
  always_comb begin
    hdr       = {target, stat, size, region, addr};
    gap       = DATA_MAX_W - data_bits(size);
    keep_mask = {DATA_MAX_W{1'b1}} >> gap;
    field     = (data & keep_mask) << gap;
    frame     = {hdr, field};
  end

endmodule

// File: rtl/trc_beat_ctr.sv
module trc_beat_ctr #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             last_beat
);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (load)           left_q <= load_val;
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign busy      = (left_q != '0);
  assign last_beat = (left_q == CNT_W'(1));

endmodule

// File: rtl/trc_lane_shifter.sv
module trc_lane_shifter
  import trc_ser_pkg::*;
#(
  parameter int unsigned FRAME_W    = 88,
  parameter int unsigned PORT_MAX_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_W-1:0]    frame_in,
  input  logic                  advance,
  input  logic [1:0]            lane_sel,
  output logic [PORT_MAX_W-1:0] lane_out
);

  localparam int unsigned N_WIDTHS = 4;

  logic [FRAME_W-1:0]    sr_q;
  logic [PORT_MAX_W-1:0] cand [N_WIDTHS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_q <= '0;
    else if (load)    sr_q <= frame_in;
    else if (advance) sr_q <= sr_q << lane_bits(lane_sel);
  end

  // One candidate slice per selectable lane width, zero-extended to the port.
  for (genvar g = 0; g < N_WIDTHS; g++) begin : g_lane
    localparam int unsigned LW = 2 << g;
    assign cand[g] = PORT_MAX_W'(sr_q[FRAME_W-1 -: LW]);
  end

  assign lane_out = cand[lane_sel];

endmodule

// File: rtl/trc_width_serializer.sv
module trc_width_serializer
  import trc_ser_pkg::*;
#(
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned PORT_MAX_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cfg_width,
  input  logic                  pkt_valid,
  output logic                  pkt_ready,
  input  logic [1:0]            pkt_target,
  input  logic [1:0]            pkt_stat,
  input  logic [1:0]            pkt_size,
  input  logic                  pkt_region,
  input  logic [ADDR_W-1:0]     pkt_addr,
  input  logic [DATA_MAX_W-1:0] pkt_data,
  output logic [PORT_MAX_W-1:0] tp_data,
  output logic                  tp_strobe
);

  localparam int unsigned HDR_W     = HDR_FIXED_W + ADDR_W;
  localparam int unsigned FRAME_W   = HDR_W + DATA_MAX_W;
  localparam int unsigned MAX_BEATS = (FRAME_W + 1) / 2;
  localparam int unsigned CNT_W     = $clog2(MAX_BEATS + 1);

  // Named internal events (observed by the bound checker)
  logic                  accept;
  logic                  busy;
  logic                  last_beat;
  logic [1:0]            pw_q;
  logic [FRAME_W-1:0]    frame;
  logic [PORT_MAX_W-1:0] lane;
  logic [CNT_W-1:0]      beat_load;

  assign pkt_ready = ~busy;
  assign accept    = pkt_valid & pkt_ready;
  assign beat_load = CNT_W'(beats_for(pkt_size, cfg_width, HDR_W));

  // Lane width is frozen at acceptance for the whole record
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pw_q <= 2'd0;
    else if (accept) pw_q <= cfg_width;
  end

  trc_frame_build #(
    .ADDR_W  (ADDR_W),
    .HDR_W   (HDR_W),
    .FRAME_W (FRAME_W)
  ) u_build (
    .target (pkt_target),
    .stat   (pkt_stat),
    .size   (pkt_size),
    .region (pkt_region),
    .addr   (pkt_addr),
    .data   (pkt_data),
    .frame  (frame)
  );

  trc_beat_ctr #(
    .CNT_W (CNT_W)
  ) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_val  (beat_load),
    .busy      (busy),
    .last_beat (last_beat)
  );

  trc_lane_shifter #(
    .FRAME_W    (FRAME_W),
    .PORT_MAX_W (PORT_MAX_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .frame_in (frame),
    .advance  (busy),
    .lane_sel (pw_q),
    .lane_out (lane)
  );

  assign tp_strobe = busy;
  assign tp_data   = busy ? lane : '0;

endmodule

// File: rtl/trc_width_serializer_chk.sv
module trc_width_serializer_chk
  import trc_ser_pkg::*;
#(
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned PORT_MAX_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  accept,
  input logic                  last_beat,
  input logic                  tp_strobe,
  input logic                  pkt_ready,
  input logic [PORT_MAX_W-1:0] tp_data,
  input logic [1:0]            pw_q,
  input logic [1:0]            pkt_size,
  input logic [1:0]            cfg_width
);

  localparam int unsigned HDR_W = HDR_FIXED_W + ADDR_W;

  int unsigned           seen_cnt;
  int unsigned           exp_cnt;
  int unsigned           exp_pad;
  logic [1:0]            cfg_seen;
  logic [PORT_MAX_W-1:0] pad_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_cnt <= 0;
      exp_cnt  <= 0;
      exp_pad  <= 0;
      cfg_seen <= 2'd0;
    end else if (accept) begin
      seen_cnt <= 0;
      exp_cnt  <= beats_for(pkt_size, cfg_width, HDR_W);
      exp_pad  <= pad_for(pkt_size, cfg_width, HDR_W);
      cfg_seen <= cfg_width;
    end else if (tp_strobe) begin
      seen_cnt <= seen_cnt + 1;
    end
  end

  always_comb pad_mask = PORT_MAX_W'((32'd1 << exp_pad) - 32'd1);

  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> tp_strobe);

  assert_no_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tp_strobe && !last_beat) |=> tp_strobe);

  assert_ready_returns_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> pkt_ready);

  assert_beat_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> (seen_cnt + 1 == exp_cnt));

  assert_beats_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tp_strobe |-> (seen_cnt < exp_cnt));

  assert_upper_lanes_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tp_strobe |-> ((tp_data >> lane_bits(pw_q)) == '0));

  assert_pad_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> ((tp_data & pad_mask) == '0));

  assert_width_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tp_strobe |-> (pw_q == cfg_seen));

endmodule

bind trc_width_serializer trc_width_serializer_chk #(
  .ADDR_W     (ADDR_W),
  .PORT_MAX_W (PORT_MAX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .last_beat (last_beat),
  .tp_strobe (tp_strobe),
  .pkt_ready (pkt_ready),
  .tp_data   (tp_data),
  .pw_q      (pw_q),
  .pkt_size  (pkt_size),
  .cfg_width (cfg_width)
);

// File: tb/trc_width_serializer_bench.sv
module trc_width_serializer_bench;

  typedef struct packed {
    logic [1:0]  tgt;
    logic [1:0]  st;
    logic [1:0]  sz;
    logic        rg;
    logic [16:0] ad;
    logic [63:0] dt;
  } rec_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_width = 2'd0;
  logic        pkt_valid = 1'b0;
  logic        pkt_ready;
  logic [1:0]  pkt_target = '0, pkt_stat = '0, pkt_size = '0;
  logic        pkt_region = 1'b0;
  logic [16:0] pkt_addr = '0;
  logic [63:0] pkt_data = '0;
  logic [15:0] tp_data;
  logic        tp_strobe;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  trc_width_serializer u_trc_width_serializer (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_width  (cfg_width),
    .pkt_valid  (pkt_valid),
    .pkt_ready  (pkt_ready),
    .pkt_target (pkt_target),
    .pkt_stat   (pkt_stat),
    .pkt_size   (pkt_size),
    .pkt_region (pkt_region),
    .pkt_addr   (pkt_addr),
    .pkt_data   (pkt_data),
    .tp_data    (tp_data),
    .tp_strobe  (tp_strobe)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Bench's own restatement of record length and lane width
  function automatic int rec_len(input logic [1:0] sz);
    case (sz)
      2'd0: return 32;
      2'd1: return 40;
      2'd2: return 56;
      default: return 88;
    endcase
  endfunction

  function automatic int lane_w(input logic [1:0] w);
    case (w)
      2'd0: return 2;
      2'd1: return 4;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic int n_beats(input logic [1:0] sz, input logic [1:0] w);
    int l, lw, n;
    l = rec_len(sz);
    lw = lane_w(w);
    n = 0;
    while (n * lw < l) n++;
    return n;
  endfunction

  // Bit number idx in send order (0 = first bit sent)
  function automatic logic rec_bit(input rec_t p, input int idx);
    logic [23:0] hdr;
    int db;
    hdr = {p.tgt, p.st, p.sz, p.rg, p.ad};
    db  = rec_len(p.sz) - 24;
    if (idx < 24) return hdr[23-idx];
    if (idx < 24 + db) return p.dt[db-1-(idx-24)];
    return 1'b0;
  endfunction

  function automatic logic [15:0] exp_beat(input rec_t p, input logic [1:0] w, input int i);
    logic [15:0] v;
    int lw;
    v  = '0;
    lw = lane_w(w);
    for (int b = 0; b < lw; b++) v[lw-1-b] = rec_bit(p, i*lw + b);
    return v;
  endfunction

  task automatic present(input rec_t p, input logic [1:0] w);
    pkt_target = p.tgt; pkt_stat = p.st; pkt_size = p.sz;
    pkt_region = p.rg;  pkt_addr = p.ad; pkt_data = p.dt;
    cfg_width  = w;
    pkt_valid  = 1'b1;
  endtask

  // Called at a negedge with a record presented and pkt_ready high.
  task automatic watch(input rec_t p, input logic [1:0] w, input string tag,
                       input rec_t nxt, input bit has_nxt, input logic [1:0] w_after);
    int n;
    n = n_beats(p.sz, w);
    @(posedge clk);
    @(negedge clk);
    if (has_nxt) present(nxt, w_after);
    else begin
      pkt_valid = 1'b0;
      cfg_width = w_after;
    end
    for (int i = 0; i < n; i++) begin
      check(tp_strobe === 1'b1, {tag, " R2/R5 strobe in beat"}, 64'(tp_strobe), 64'd1);
      check(tp_data === exp_beat(p, w, i), {tag, " R3/R4/R6 beat data"},
            64'(tp_data), 64'(exp_beat(p, w, i)));
      check(pkt_ready === 1'b0, {tag, " R7 ready low while shifting"}, 64'(pkt_ready), 64'd0);
      @(negedge clk);
    end
    check(tp_strobe === 1'b0, {tag, " R5 strobe ends after beat count"}, 64'(tp_strobe), 64'd0);
    check(tp_data === 16'h0, {tag, " R9 idle data zero"}, 64'(tp_data), 64'd0);
    check(pkt_ready === 1'b1, {tag, " R7 ready after last beat"}, 64'(pkt_ready), 64'd1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(pkt_ready === 1'b1, "R1 ready after reset", 64'(pkt_ready), 64'd1);
    check(tp_strobe === 1'b0, "R1 strobe after reset", 64'(tp_strobe), 64'd0);
    check(tp_data === 16'h0, "R1 data after reset", 64'(tp_data), 64'd0);
  endtask

  task automatic t_known_record();
    rec_t p;
    p = '{tgt: 2'd2, st: 2'd1, sz: 2'd1, rg: 1'b1, ad: 17'h12345, dt: 64'h1234_5678_9ABC_BEEF};
    present(p, 2'd3);
    @(posedge clk);
    @(negedge clk);
    pkt_valid = 1'b0;
    check(tp_data === 16'h9723, "R3 known record beat 0", 64'(tp_data), 64'h9723);
    @(negedge clk);
    check(tp_data === 16'h45BE, "R3 known record beat 1", 64'(tp_data), 64'h45BE);
    @(negedge clk);
    check(tp_data === 16'hEF00, "R6 known record padded beat 2", 64'(tp_data), 64'hEF00);
    @(negedge clk);
    check(tp_strobe === 1'b0, "R5 known record takes 3 beats", 64'(tp_strobe), 64'd0);
  endtask

  task automatic t_sweep();
    rec_t p;
    for (int w = 0; w < 4; w++) begin
      for (int s = 0; s < 4; s++) begin
        p.tgt = 2'(w + s);
        p.st  = 2'(3 - s);
        p.sz  = 2'(s);
        p.rg  = 1'(w);
        p.ad  = 17'(32'h1A5C3 ^ (w * 32'h0F0F + s * 32'h3333));
        p.dt  = 64'hF0E1_D2C3_B4A5_9687 ^ {8{8'(w * 16 + s * 37)}};
        present(p, 2'(w));
        watch(p, 2'(w), "sweep", p, 1'b0, 2'(w));
      end
    end
  endtask

  task automatic t_ignore_high_data();
    rec_t p;
    p = '{tgt: 2'd1, st: 2'd0, sz: 2'd0, rg: 1'b0, ad: 17'h00F0F, dt: 64'hFFFF_FFFF_FFFF_FF5A};
    present(p, 2'd2);
    watch(p, 2'd2, "R10 upper data ignored", p, 1'b0, 2'd2);
  endtask

  task automatic t_width_change_mid();
    rec_t p, q;
    p = '{tgt: 2'd3, st: 2'd2, sz: 2'd2, rg: 1'b1, ad: 17'h1FFFF, dt: 64'h0000_0000_C001_D00D};
    q = '{tgt: 2'd0, st: 2'd3, sz: 2'd3, rg: 1'b0, ad: 17'h00001, dt: 64'h8877_6655_4433_2211};
    present(p, 2'd1);
    watch(p, 2'd1, "R8 old width kept", p, 1'b0, 2'd3);
    present(q, 2'd3);
    watch(q, 2'd3, "R8 new width applied", q, 1'b0, 2'd3);
  endtask

  task automatic t_back_to_back();
    rec_t p, q;
    p = '{tgt: 2'd2, st: 2'd3, sz: 2'd3, rg: 1'b1, ad: 17'h0ACE1, dt: 64'hDEAD_BEEF_0BAD_F00D};
    q = '{tgt: 2'd1, st: 2'd1, sz: 2'd1, rg: 1'b0, ad: 17'h15555, dt: 64'h0000_0000_0000_A55A};
    present(p, 2'd2);
    // second record held on the input during the whole first record (R7)
    watch(p, 2'd2, "R7 first of pair", q, 1'b1, 2'd0);
    watch(q, 2'd0, "R7 held record taken", q, 1'b0, 2'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_known_record();
    t_sweep();
    t_ignore_high_data();
    t_width_change_mid();
    t_back_to_back();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule